// File: doc/BRIEF.md
# UART Status Flags with Sequenced Clearing

This unit holds the software-visible status of a UART that has a single receive holding register and a single transmit holding register. It keeps three flags: receive holding register full, receive overrun, and transmit holding register empty. The bit-level receiver and transmitter stay outside the unit. The receiver reports each finished frame with a one-cycle pulse and the byte. The transmitter reports with a one-cycle pulse when it takes the held byte into its shifter. The CPU side uses three one-cycle strobes: status read, receive-data read and transmit-data write.

A flag does not clear on a single access. Software first reads the status. At that read the unit records which flags were 1 and arms a clear for each of them. The next access to the matching data register then clears the armed flags and uses up the arm. A flag that rises after the status read is not armed, so it survives the following data access, and software has to read the status again. While an overrun is pending, the receiver is held off: new frames are dropped and the earlier byte stays in the holding register.

Top module: `uart_flag_unit`

## Requirements
- R1: After reset, tx_empty is 1, rx_full is 0, rx_overrun is 0, rx_enable is 1, rx_irq is 0, and both data outputs are 0. No clear is armed.
- R2: rx_done while rx_full is 0 and rx_overrun is 0 loads rx_byte into rx_data and sets rx_full. On the clock edge that follows, rx_irq goes high for exactly one cycle.
- R3: rd_rxd clears rx_full only if rx_full was 1 at the most recent status read and no receive-data read has occurred since then. An rd_rxd with no such arm leaves rx_full unchanged.
- R4: rx_done while rx_full is 1 (and not cleared in the same cycle) and rx_overrun is 0 sets rx_overrun and drops the new byte, so rx_data keeps its value. It also raises a one-cycle rx_irq. rx_enable equals the inverse of rx_overrun.
- R5: While rx_overrun is 1, rx_done has no effect: rx_data, rx_full and rx_irq stay unchanged.
- R6: A status read taken while rx_overrun is 1, followed by rd_rxd, clears rx_overrun together with any armed rx_full. After that, frames load again.
- R7: If rx_overrun rises after a status read, the following rd_rxd leaves rx_overrun set. Only a new status read followed by rd_rxd clears it.
- R8: tx_start sets tx_empty to 1.
- R9: wr_txd always stores wdata in tx_data. It clears tx_empty only if tx_empty was 1 at the most recent status read and no transmit-data write has occurred since then.
- R10: A single status read arms at most one clearing access per data register. A second rd_rxd or wr_txd without a new status read clears nothing.
- R11: A flag that was 0 at the status read is not armed. If tx_start sets tx_empty after that read, the next wr_txd leaves tx_empty at 1.
- R12: If rd_rxd clears rx_full in the same cycle as rx_done, the frame loads and rx_full stays 1 without an overrun. If wr_txd clears tx_empty in the same cycle as tx_start, tx_empty ends at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_done | input | 1 | One-cycle pulse: the receiver finished a frame |
| rx_byte | input | DATA_W | Byte of the finished frame |
| tx_start | input | 1 | One-cycle pulse: the transmitter took the held byte |
| rd_stat | input | 1 | CPU status read strobe |
| rd_rxd | input | 1 | CPU receive-data read strobe |
| wr_txd | input | 1 | CPU transmit-data write strobe |
| wdata | input | DATA_W | CPU write data for the transmit register |
| rx_full | output | 1 | Receive holding register full flag |
| rx_overrun | output | 1 | Receive overrun flag |
| tx_empty | output | 1 | Transmit holding register empty flag |
| rx_data | output | DATA_W | Receive holding register |
| tx_data | output | DATA_W | Transmit holding register |
| rx_enable | output | 1 | High when the receiver may deliver frames |
| rx_irq | output | 1 | One-cycle receive interrupt pulse |

## Verification
The hidden state is the set of three arm bits, and it shows at the ports only when the next data-register access takes place. An arm that is stuck high, or one that is never used up, shows as a flag falling one cycle after a second or unarmed access. An arm missing from a snapshot shows as a flag that stays high after a correct read sequence. Faults in the flag or holding registers appear on the outputs one cycle after the strobe or pulse that caused them. An overrun that fails to block reception shows as rx_data changing on the next frame.

// File: rtl/uart_flag_pkg.sv
package uart_flag_pkg;

  // One bit per status flag; used both for the flags and for their arms.
  typedef struct packed {
    logic tbe;   // transmit holding register empty
    logic ovr;   // receive overrun
    logic rbf;   // receive holding register full
  } flag_set_t;

  localparam flag_set_t FLAGS_RESET = '{tbe: 1'b1, ovr: 1'b0, rbf: 1'b0};
  localparam flag_set_t FLAGS_NONE  = '{tbe: 1'b0, ovr: 1'b0, rbf: 1'b0};

endpackage

// File: rtl/ufl_rst_sync.sv
module ufl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= chain_d;
  end

  assign rst_n_out = chain_q[STAGES-1];

endmodule

// File: rtl/ufl_arm_tracker.sv
module ufl_arm_tracker
  import uart_flag_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rd_stat,
  input  logic      rd_rxd,
  input  logic      wr_txd,
  input  flag_set_t flags,
  output flag_set_t arm
);

  flag_set_t arm_q;
  flag_set_t arm_d;
  logic      arm_en;

  // A status read takes a fresh snapshot. A data access otherwise uses up
  // the arms that belong to its register.
  always_comb begin
    arm_d  = arm_q;
    arm_en = rd_stat | rd_rxd | wr_txd;
    if (rd_stat) begin
      arm_d = flags;
    end else begin
      if (rd_rxd) begin
        arm_d.rbf = 1'b0;
        arm_d.ovr = 1'b0;
      end
      if (wr_txd) begin
        arm_d.tbe = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      arm_q <= FLAGS_NONE;
    else if (arm_en) arm_q <= arm_d;
  end

  assign arm = arm_q;

  AST_RBF_ARM_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arm_q.rbf) |-> $past(rd_stat)); // R10
  AST_TBE_ARM_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arm_q.tbe) |-> $past(rd_stat)); // R11
  AST_ARM_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arm_q.ovr) |-> $past(flags.ovr)); // R7

endmodule

// File: rtl/ufl_rx_path.sv
module ufl_rx_path #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_done,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              rd_rxd,
  input  logic              arm_rbf,
  input  logic              arm_ovr,
  output logic              rbf,
  output logic              ovr,
  output logic [DATA_W-1:0] data,
  output logic              irq
);

  logic              rbf_q, rbf_d;
  logic              ovr_q, ovr_d;
  logic [DATA_W-1:0] data_q;
  logic              irq_q, irq_d;
  logic              clr_rbf, clr_ovr, accept, room, load, overrun;

  always_comb begin
    clr_rbf = rd_rxd & arm_rbf;
    clr_ovr = rd_rxd & arm_ovr;
    accept  = rx_done & ~ovr_q;
    room    = ~rbf_q | clr_rbf;
    load    = accept & room;
    overrun = accept & ~room;

    rbf_d = rbf_q;
    if (load)         rbf_d = 1'b1;
    else if (clr_rbf) rbf_d = 1'b0;

    ovr_d = ovr_q;
    if (overrun)      ovr_d = 1'b1;
    else if (clr_ovr) ovr_d = 1'b0;

    irq_d = load | overrun;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbf_q <= 1'b0;
      ovr_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      rbf_q <= rbf_d;
      ovr_q <= ovr_d;
      irq_q <= irq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    data_q <= '0;
    else if (load) data_q <= rx_byte;
  end

  assign rbf  = rbf_q;
  assign ovr  = ovr_q;
  assign data = data_q;
  assign irq  = irq_q;

  AST_RBF_CLEAR_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rbf_q) |-> $past(rd_rxd && arm_rbf)); // R3
  AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> $past(rbf_q)); // R4
  AST_OVR_FREEZES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |=> $stable(data_q)); // R5
  AST_OVR_CLEAR_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovr_q) |-> $past(rd_rxd && arm_ovr)); // R6
  AST_IRQ_FROM_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(rx_done)); // R2
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q && !rx_done |=> !irq_q); // R2

endmodule

// File: rtl/ufl_tx_path.sv
module ufl_tx_path #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_start,
  input  logic              wr_txd,
  input  logic [DATA_W-1:0] wdata,
  input  logic              arm_tbe,
  output logic              tbe,
  output logic [DATA_W-1:0] data
);

  logic              tbe_q, tbe_d;
  logic [DATA_W-1:0] data_q;
  logic              clr_tbe;

  // A clearing write wins over a shifter take in the same cycle: the new
  // byte is the one left waiting in the holding register.
  always_comb begin
    clr_tbe = wr_txd & arm_tbe;
    tbe_d   = tbe_q;
    if (clr_tbe)       tbe_d = 1'b0;
    else if (tx_start) tbe_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tbe_q <= 1'b1;
    else        tbe_q <= tbe_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      data_q <= '0;
    else if (wr_txd) data_q <= wdata;
  end

  assign tbe  = tbe_q;
  assign data = data_q;

  AST_TBE_CLEAR_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tbe_q) |-> $past(wr_txd && arm_tbe)); // R9
  AST_TBE_SET_BY_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tbe_q) |-> $past(tx_start)); // R8
  AST_TBE_START_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start && !wr_txd |=> tbe_q); // R8

endmodule

// File: rtl/uart_flag_unit.sv
module uart_flag_unit
  import uart_flag_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_done,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              tx_start,
  input  logic              rd_stat,
  input  logic              rd_rxd,
  input  logic              wr_txd,
  input  logic [DATA_W-1:0] wdata,
  output logic              rx_full,
  output logic              rx_overrun,
  output logic              tx_empty,
  output logic [DATA_W-1:0] rx_data,
  output logic [DATA_W-1:0] tx_data,
  output logic              rx_enable,
  output logic              rx_irq
);

  logic      rst_n_sync;
  flag_set_t flags;
  flag_set_t arm;

  ufl_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_sync)
  );

  ufl_arm_tracker u_arm (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .rd_stat (rd_stat),
    .rd_rxd  (rd_rxd),
    .wr_txd  (wr_txd),
    .flags   (flags),
    .arm     (arm)
  );

  ufl_rx_path #(.DATA_W(DATA_W)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .rx_done (rx_done),
    .rx_byte (rx_byte),
    .rd_rxd  (rd_rxd),
    .arm_rbf (arm.rbf),
    .arm_ovr (arm.ovr),
    .rbf     (flags.rbf),
    .ovr     (flags.ovr),
    .data    (rx_data),
    .irq     (rx_irq)
  );

  ufl_tx_path #(.DATA_W(DATA_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .tx_start (tx_start),
    .wr_txd   (wr_txd),
    .wdata    (wdata),
    .arm_tbe  (arm.tbe),
    .tbe      (flags.tbe),
    .data     (tx_data)
  );

  assign rx_full    = flags.rbf;
  assign rx_overrun = flags.ovr;
  assign tx_empty   = flags.tbe;
  assign rx_enable  = ~flags.ovr;

  AST_ENABLE_TRACKS_OVR: assert property (@(posedge clk) disable iff (!rst_n_sync)
    rx_overrun |=> !rx_enable || !rx_overrun); // R4
  AST_OVR_WITH_FULL: assert property (@(posedge clk) disable iff (!rst_n_sync)
    $rose(rx_overrun) |-> rx_full); // R4

endmodule

// File: tb/sim_uart_flag_unit.sv
module sim_uart_flag_unit;

  localparam int DW = 8;
  localparam logic [4:0] C_NONE = 5'b00000;
  localparam logic [4:0] C_ST   = 5'b10000;
  localparam logic [4:0] C_RR   = 5'b01000;
  localparam logic [4:0] C_TW   = 5'b00100;
  localparam logic [4:0] C_RD   = 5'b00010;
  localparam logic [4:0] C_TS   = 5'b00001;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n, rx_done, tx_start, rd_stat, rd_rxd, wr_txd;
  logic [DW-1:0] rx_byte, wdata;
  logic          rx_full, rx_overrun, tx_empty, rx_enable, rx_irq;
  logic [DW-1:0] rx_data, tx_data;

  uart_flag_unit #(.DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_done(rx_done), .rx_byte(rx_byte),
    .tx_start(tx_start), .rd_stat(rd_stat), .rd_rxd(rd_rxd),
    .wr_txd(wr_txd), .wdata(wdata), .rx_full(rx_full),
    .rx_overrun(rx_overrun), .tx_empty(tx_empty), .rx_data(rx_data),
    .tx_data(tx_data), .rx_enable(rx_enable), .rx_irq(rx_irq)
  );

  typedef struct {
    string         tag;
    logic [2:0]    f;    // {rx_full, rx_overrun, tx_empty}
    logic [DW-1:0] rxd;
    logic [DW-1:0] txd;
    logic          irq;
  } exp_t;

  exp_t q[$];
  int   total = 0;
  int   bad   = 0;

  // Driver: apply one cycle of stimulus and queue the outputs expected after the edge.
  task automatic go(input string tag, input logic [4:0] c, input logic [DW-1:0] b,
                    input logic [DW-1:0] w, input logic [2:0] f,
                    input logic [DW-1:0] erx, input logic [DW-1:0] etx, input logic ei);
    exp_t x;
    @(negedge clk);
    {rd_stat, rd_rxd, wr_txd, rx_done, tx_start} = c;
    rx_byte = b;
    wdata   = w;
    x.tag = tag; x.f = f; x.rxd = erx; x.txd = etx; x.irq = ei;
    q.push_back(x);
  endtask

  // Monitor: compare after each edge, away from it.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t x;
        logic [2:0] got;
        x = q.pop_front();
        got = {rx_full, rx_overrun, tx_empty};
        total++;
        if (got !== x.f || rx_data !== x.rxd || tx_data !== x.txd ||
            rx_irq !== x.irq || rx_enable !== ~x.f[1]) begin
          bad++;
          $display("FAIL %s: got f=%b rxd=%h txd=%h irq=%b en=%b exp f=%b rxd=%h txd=%h irq=%b en=%b",
                   x.tag, got, rx_data, tx_data, rx_irq, rx_enable,
                   x.f, x.rxd, x.txd, x.irq, ~x.f[1]);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL R1 watchdog: run exceeded %0d cycles, expected completion", 20000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    {rd_stat, rd_rxd, wr_txd, rx_done, tx_start} = C_NONE;
    rx_byte = '0;
    wdata   = '0;
    repeat (3) @(negedge clk);
    total++;
    if ({rx_full, rx_overrun, tx_empty} !== 3'b001 || rx_data !== '0 ||
        tx_data !== '0 || rx_irq !== 1'b0 || rx_enable !== 1'b1) begin
      bad++;
      $display("FAIL R1 reset: got f=%b rxd=%h txd=%h irq=%b en=%b exp f=001 rxd=00 txd=00 irq=0 en=1",
               {rx_full, rx_overrun, tx_empty}, rx_data, tx_data, rx_irq, rx_enable);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    go("R1 idle",          C_NONE,      8'h00, 8'h00, 3'b001, 8'h00, 8'h00, 1'b0);
    go("R2 load",          C_RD,        8'hA5, 8'h00, 3'b101, 8'hA5, 8'h00, 1'b1);
    go("R2 irq single",    C_NONE,      8'h00, 8'h00, 3'b101, 8'hA5, 8'h00, 1'b0);
    go("R3 unarmed read",  C_RR,        8'h00, 8'h00, 3'b101, 8'hA5, 8'h00, 1'b0);
    go("R3 status",        C_ST,        8'h00, 8'h00, 3'b101, 8'hA5, 8'h00, 1'b0);
    go("R3 armed read",    C_RR,        8'h00, 8'h00, 3'b001, 8'hA5, 8'h00, 1'b0);
    go("R10 reload",       C_RD,        8'h3C, 8'h00, 3'b101, 8'h3C, 8'h00, 1'b1);
    go("R10 arm used",     C_RR,        8'h00, 8'h00, 3'b101, 8'h3C, 8'h00, 1'b0);
    go("R4 overrun",       C_RD,        8'h77, 8'h00, 3'b111, 8'h3C, 8'h00, 1'b1);
    go("R5 frozen",        C_RD,        8'h11, 8'h00, 3'b111, 8'h3C, 8'h00, 1'b0);
    go("R6 status",        C_ST,        8'h00, 8'h00, 3'b111, 8'h3C, 8'h00, 1'b0);
    go("R6 clear ovr",     C_RR,        8'h00, 8'h00, 3'b001, 8'h3C, 8'h00, 1'b0);
    go("R6 resume",        C_RD,        8'h42, 8'h00, 3'b101, 8'h42, 8'h00, 1'b1);
    go("R7 status",        C_ST,        8'h00, 8'h00, 3'b101, 8'h42, 8'h00, 1'b0);
    go("R7 late overrun",  C_RD,        8'h99, 8'h00, 3'b111, 8'h42, 8'h00, 1'b1);
    go("R7 ovr survives",  C_RR,        8'h00, 8'h00, 3'b011, 8'h42, 8'h00, 1'b0);
    go("R5 empty frozen",  C_RD,        8'h55, 8'h00, 3'b011, 8'h42, 8'h00, 1'b0);
    go("R7 status again",  C_ST,        8'h00, 8'h00, 3'b011, 8'h42, 8'h00, 1'b0);
    go("R7 ovr cleared",   C_RR,        8'h00, 8'h00, 3'b001, 8'h42, 8'h00, 1'b0);
    go("R12 load",         C_RD,        8'h10, 8'h00, 3'b101, 8'h10, 8'h00, 1'b1);
    go("R12 status",       C_ST,        8'h00, 8'h00, 3'b101, 8'h10, 8'h00, 1'b0);
    go("R12 clear+load",   C_RR | C_RD, 8'h20, 8'h00, 3'b101, 8'h20, 8'h00, 1'b1);
    go("R9 armed write",   C_TW,        8'h00, 8'hC3, 3'b100, 8'h20, 8'hC3, 1'b0);
    go("R10 tx arm used",  C_TW,        8'h00, 8'hD4, 3'b100, 8'h20, 8'hD4, 1'b0);
    go("R8 start",         C_TS,        8'h00, 8'h00, 3'b101, 8'h20, 8'hD4, 1'b0);
    go("R9 unarmed write", C_TW,        8'h00, 8'hE5, 3'b101, 8'h20, 8'hE5, 1'b0);
    go("R9 status",        C_ST,        8'h00, 8'h00, 3'b101, 8'h20, 8'hE5, 1'b0);
    go("R9 clear",         C_TW,        8'h00, 8'h66, 3'b100, 8'h20, 8'h66, 1'b0);
    go("R11 status zero",  C_ST,        8'h00, 8'h00, 3'b100, 8'h20, 8'h66, 1'b0);
    go("R11 late start",   C_TS,        8'h00, 8'h00, 3'b101, 8'h20, 8'h66, 1'b0);
    go("R11 not armed",    C_TW,        8'h00, 8'h77, 3'b101, 8'h20, 8'h77, 1'b0);
    go("R12 tx status",    C_ST,        8'h00, 8'h00, 3'b101, 8'h20, 8'h77, 1'b0);
    go("R12 tx clear",     C_TW,        8'h00, 8'h88, 3'b100, 8'h20, 8'h88, 1'b0);
    go("R8 start again",   C_TS,        8'h00, 8'h00, 3'b101, 8'h20, 8'h88, 1'b0);
    go("R12 tx status 2",  C_ST,        8'h00, 8'h00, 3'b101, 8'h20, 8'h88, 1'b0);
    go("R12 write+start",  C_TW | C_TS, 8'h00, 8'h99, 3'b100, 8'h20, 8'h99, 1'b0);
    go("R1 quiet",         C_NONE,      8'h00, 8'h00, 3'b100, 8'h20, 8'h99, 1'b0);

    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule